// File: doc/BRIEF.md
# Host Command Transaction Sequencer

This block acts as a bus master on a simple register bus and runs one complete command transaction against a command/response buffer style device. A single start pulse launches the sequence. The block first finds and claims the active locality. It checks that no earlier command is still running and moves the device into its ready state. It then hands control to an external copy engine, which loads the command payload. After that it starts execution and polls for completion and for a device error. Next it reads the response length, which is stored big-endian, and asks the copy engine to move the response out. Finally it returns the device to ready. The outcome is reported as a single-cycle pulse on one of three lines: done, error or timeout.

Each wait in the sequence is a masked compare, (read & mask) == expected. The compare repeats until it matches or until a per-step cycle counter reaches that step's budget. Each budget is a fixed number of units multiplied by the `CYC_PER_UNIT` parameter. The register bus and both copy-engine handshakes are valid/ready. A request stays asserted, with address, direction and write data unchanged, until the slave raises ready. When the slave stalls, the sequencer simply waits, and the stalled cycles still count against the step budget.

Top module: `hcs_sequencer`

## Requirements
- R1: On a start pulse while idle, the transaction is rejected before any bus activity when cmd_size_i > cap_cmd_i or cap_rsp_i < max_rsp_i. An error pulse appears one cycle after start, and bus_valid_o stays low.
- R2: The first bus access is a read of register offset 0x000 at locality 0. Its bits 4:2 give the locality L, and every later register access goes to BASE_ADDR + L*0x1000 + offset.
- R3: The sequencer polls offset 0x000 for bit 1 set, with a budget of 750 units. On expiry it writes 0x1 to offset 0x008 and polls bit 1 again for 750 units; a second expiry is a timeout. After an access request, or when L is non-zero, it also polls bit 7 set within 1500 units. Locality 0 that is assigned on the first poll skips that check.
- R4: Before ready, offset 0x04C bit 0 must read clear within 250 units, or the transaction ends with a timeout and no write to offset 0x040.
- R5: To enter ready, the sequencer writes 0x1 to offset 0x040 and polls that bit clear within 200 units (expiry is a timeout). It then polls offset 0x044 bit 0 clear within 500 units (expiry is an error, and execution is never started).
- R6: After the load handshake (ld_valid_o/ld_ready_i), the sequencer writes 0x1 to offset 0x04C and polls bit 0 clear within 3500 units. Expiry is a timeout.
- R7: After completion, offset 0x044 bit 0 must read clear within 200 units. Otherwise the transaction ends with an error and no response copy.
- R8: The response length is read as words at RSP_ADDR and RSP_ADDR+4. The length is bytes 2,3,4,5 taken most significant first: {w0[23:16], w0[31:24], w1[7:0], w1[15:8]}. A length below 6 ends with an error and no copy.
- R9: A valid length is offered on cp_len_o through cp_valid_o/cp_ready_i. After that the ready request of R5 is repeated, and done pulses with rsp_len_o holding the length.
- R10: At most one of done_o, err_o and tmo_o is high in any cycle. Each is a single-cycle pulse, and busy_o is low in that cycle. After reset all three are low.
- R11: A start pulse while busy_o is high is ignored. A start in the same cycle as an outcome pulse is accepted as a new transaction.
- R12: A bus or handshake request held against a low ready keeps its address, direction, data and length unchanged.
- R13: A timeout is declared only on a non-matching read completed when at least budget cycles have passed since the step began. A matching read that completes after the budget still counts as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction request pulse |
| cmd_size_i | input | SZ_W | Command size in bytes |
| max_rsp_i | input | SZ_W | Caller's maximum response size |
| cap_cmd_i | input | SZ_W | Device command buffer capacity |
| cap_rsp_i | input | SZ_W | Device response buffer capacity |
| busy_o | output | 1 | Transaction in flight |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Error pulse |
| tmo_o | output | 1 | Timeout pulse |
| rsp_len_o | output | 32 | Last response length read |
| bus_valid_o | output | 1 | Bus request valid |
| bus_ready_i | input | 1 | Bus request accepted; read data valid |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data |
| ld_valid_o | output | 1 | Command load requested |
| ld_ready_i | input | 1 | Command load finished |
| cp_valid_o | output | 1 | Response copy requested |
| cp_ready_i | input | 1 | Response copy finished |
| cp_len_o | output | 32 | Response length to copy |

## Verification
Two functions can land in the same cycle. The first pair is budget expiry and a matching poll. The bench stalls bus ready for longer than the 3500-unit completion budget and then returns a clear start bit. This must count as success, because expiry acts only on a read that does not match. The second pair is an outcome pulse and a new start. The bench raises start in the very cycle that done is high and expects a second full transaction, each outcome judged in order by the scoreboard.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_LOC_RD, S_ASG1, S_ACC_WR, S_ASG2, S_VLD, S_STR_CHK,
    S_RDY_WR, S_RDY_POLL, S_RDY_STS, S_LOAD, S_GO_WR, S_GO_POLL,
    S_END_STS, S_RSP0, S_RSP1, S_COPY, S_RET_WR, S_RET_POLL, S_RET_STS
  } seq_state_e;

  typedef enum logic [2:0] {K_NONE, K_READ, K_WRITE, K_POLL, K_HAND} step_kind_e;

  // register offsets inside one locality window (decoded by the device)
  localparam logic [11:0] OFS_LSTATE = 12'h000;
  localparam logic [11:0] OFS_LCTRL  = 12'h008;
  localparam logic [11:0] OFS_REQ    = 12'h040;
  localparam logic [11:0] OFS_STS    = 12'h044;
  localparam logic [11:0] OFS_GO     = 12'h04C;

  // step budgets in units
  localparam logic [11:0] U_ASSIGN = 12'd750;
  localparam logic [11:0] U_VALID  = 12'd1500;
  localparam logic [11:0] U_IDLECK = 12'd250;
  localparam logic [11:0] U_RDY    = 12'd200;
  localparam logic [11:0] U_RDYSTS = 12'd500;
  localparam logic [11:0] U_EXEC   = 12'd3500;
  localparam logic [11:0] U_ENDSTS = 12'd200;

endpackage

// File: rtl/hcs_step_timer.sv
module hcs_step_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/hcs_len_unpack.sv
module hcs_len_unpack #(
  parameter int MIN_LEN = 6
) (
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  output logic [31:0] len,
  output logic        too_short
);
  // bytes 2..5 of the buffer, most significant byte first
  assign len       = {lo_word[23:16], lo_word[31:24], hi_word[7:0], hi_word[15:8]};
  assign too_short = (len < 32'(MIN_LEN));
endmodule

// File: rtl/hcs_sequencer.sv
module hcs_sequencer
  import hcs_pkg::*;
#(
  parameter int             AW           = 16,
  parameter int             SZ_W         = 16,
  parameter logic [AW-1:0]  BASE_ADDR    = '0,
  parameter logic [AW-1:0]  RSP_ADDR     = 16'h8000,
  parameter int             CYC_PER_UNIT = 1000,
  parameter int             MIN_RSP      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [SZ_W-1:0] cmd_size_i,
  input  logic [SZ_W-1:0] max_rsp_i,
  input  logic [SZ_W-1:0] cap_cmd_i,
  input  logic [SZ_W-1:0] cap_rsp_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            tmo_o,
  output logic [31:0]     rsp_len_o,
  output logic            bus_valid_o,
  input  logic            bus_ready_i,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [31:0]     bus_wdata_o,
  input  logic [31:0]     bus_rdata_i,
  output logic            ld_valid_o,
  input  logic            ld_ready_i,
  output logic            cp_valid_o,
  input  logic            cp_ready_i,
  output logic [31:0]     cp_len_o
);
  localparam int CNT_W = 32;

  seq_state_e state_q, state_d;
  logic [2:0]  loc_q;
  logic [31:0] w0_q, len_q;
  logic        done_q, err_q, tmo_q;

  // step descriptor
  step_kind_e  d_kind;
  logic        d_loc0, d_abs, d_is_err;
  logic [11:0] d_ofs, d_units;
  logic [AW-1:0] d_abs_addr;
  logic [7:0]  d_mask, d_exp;
  seq_state_e  d_next;

  always_comb begin
    d_kind = K_NONE; d_loc0 = 1'b0; d_abs = 1'b0; d_is_err = 1'b0;
    d_ofs = OFS_LSTATE; d_units = '0; d_abs_addr = RSP_ADDR;
    d_mask = 8'h01; d_exp = 8'h00; d_next = S_IDLE;
    case (state_q)
      S_LOC_RD:   begin d_kind = K_READ; d_loc0 = 1'b1; d_next = S_ASG1; end
      S_ASG1:     begin d_kind = K_POLL; d_mask = 8'h02; d_exp = 8'h02; d_units = U_ASSIGN;
                        d_next = (loc_q == 3'd0) ? S_STR_CHK : S_VLD; end
      S_ACC_WR:   begin d_kind = K_WRITE; d_ofs = OFS_LCTRL; d_next = S_ASG2; end
      S_ASG2:     begin d_kind = K_POLL; d_mask = 8'h02; d_exp = 8'h02; d_units = U_ASSIGN;
                        d_next = S_VLD; end
      S_VLD:      begin d_kind = K_POLL; d_mask = 8'h80; d_exp = 8'h80; d_units = U_VALID;
                        d_next = S_STR_CHK; end
      S_STR_CHK:  begin d_kind = K_POLL; d_ofs = OFS_GO; d_units = U_IDLECK; d_next = S_RDY_WR; end
      S_RDY_WR:   begin d_kind = K_WRITE; d_ofs = OFS_REQ; d_next = S_RDY_POLL; end
      S_RDY_POLL: begin d_kind = K_POLL; d_ofs = OFS_REQ; d_units = U_RDY; d_next = S_RDY_STS; end
      S_RDY_STS:  begin d_kind = K_POLL; d_ofs = OFS_STS; d_units = U_RDYSTS; d_is_err = 1'b1;
                        d_next = S_LOAD; end
      S_LOAD:     begin d_kind = K_HAND; d_next = S_GO_WR; end
      S_GO_WR:    begin d_kind = K_WRITE; d_ofs = OFS_GO; d_next = S_GO_POLL; end
      S_GO_POLL:  begin d_kind = K_POLL; d_ofs = OFS_GO; d_units = U_EXEC; d_next = S_END_STS; end
      S_END_STS:  begin d_kind = K_POLL; d_ofs = OFS_STS; d_units = U_ENDSTS; d_is_err = 1'b1;
                        d_next = S_RSP0; end
      S_RSP0:     begin d_kind = K_READ; d_abs = 1'b1; d_next = S_RSP1; end
      S_RSP1:     begin d_kind = K_READ; d_abs = 1'b1; d_abs_addr = RSP_ADDR + AW'(4);
                        d_next = S_COPY; end
      S_COPY:     begin d_kind = K_HAND; d_next = S_RET_WR; end
      S_RET_WR:   begin d_kind = K_WRITE; d_ofs = OFS_REQ; d_next = S_RET_POLL; end
      S_RET_POLL: begin d_kind = K_POLL; d_ofs = OFS_REQ; d_units = U_RDY; d_next = S_RET_STS; end
      S_RET_STS:  begin d_kind = K_POLL; d_ofs = OFS_STS; d_units = U_RDYSTS; d_is_err = 1'b1;
                        d_next = S_IDLE; end
      default:    ;
    endcase
  end

  // bus request
  assign bus_valid_o = (d_kind == K_READ) || (d_kind == K_WRITE) || (d_kind == K_POLL);
  assign bus_we_o    = (d_kind == K_WRITE);
  assign bus_wdata_o = bus_we_o ? 32'h1 : 32'h0;
  assign bus_addr_o  = d_abs ? d_abs_addr
                             : BASE_ADDR + AW'({(d_loc0 ? 3'd0 : loc_q), d_ofs});

  logic bus_acc, poll_hit, hand_fire;
  assign bus_acc   = bus_valid_o && bus_ready_i;
  assign poll_hit  = ((bus_rdata_i[7:0] & d_mask) == d_exp);
  assign ld_valid_o = (state_q == S_LOAD);
  assign cp_valid_o = (state_q == S_COPY);
  assign hand_fire = (ld_valid_o && ld_ready_i) || (cp_valid_o && cp_ready_i);

  // response length
  logic [31:0] unp_len;
  logic        unp_short;
  hcs_len_unpack #(.MIN_LEN(MIN_RSP)) u_unpack (
    .lo_word(w0_q), .hi_word(bus_rdata_i), .len(unp_len), .too_short(unp_short)
  );

  // per-step budget timer
  logic tmr_expired, tmr_clr;
  logic [CNT_W-1:0] budget;
  assign budget = CNT_W'(d_units) * CNT_W'(CYC_PER_UNIT);
  hcs_step_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(budget), .expired(tmr_expired)
  );

  logic size_bad, end_done, end_err, end_tmo;
  assign size_bad = (cmd_size_i > cap_cmd_i) || (cap_rsp_i < max_rsp_i);

  always_comb begin
    state_d = state_q; end_done = 1'b0; end_err = 1'b0; end_tmo = 1'b0;
    if (state_q == S_IDLE) begin
      if (start_i) begin
        if (size_bad) end_err = 1'b1;
        else          state_d = S_LOC_RD;
      end
    end else begin
      case (d_kind)
        K_READ:  if (bus_acc) begin
                   if (state_q == S_RSP1 && unp_short) begin
                     end_err = 1'b1; state_d = S_IDLE;
                   end else state_d = d_next;
                 end
        K_WRITE: if (bus_acc) state_d = d_next;
        K_POLL:  if (bus_acc) begin
                   if (poll_hit) begin
                     state_d  = d_next;
                     end_done = (state_q == S_RET_STS);
                   end else if (tmr_expired) begin
                     if (state_q == S_ASG1) state_d = S_ACC_WR;
                     else begin
                       state_d = S_IDLE;
                       end_err = d_is_err;
                       end_tmo = !d_is_err;
                     end
                   end
                 end
        K_HAND:  if (hand_fire) state_d = d_next;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; loc_q <= '0; w0_q <= '0; len_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= end_done;
      err_q   <= end_err;
      tmo_q   <= end_tmo;
      if (bus_acc && state_q == S_LOC_RD) loc_q <= bus_rdata_i[4:2];
      if (bus_acc && state_q == S_RSP0)   w0_q  <= bus_rdata_i;
      if (bus_acc && state_q == S_RSP1)   len_q <= unp_len;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign tmo_o     = tmo_q;
  assign rsp_len_o = len_q;
  assign cp_len_o  = len_q;

  // R10: outcomes are exclusive and never overlap a busy cycle
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, tmo_o}));
  a_r10_idle_on_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o || tmo_o) |-> !busy_o);
  // R1: no bus traffic outside a transaction
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_valid_o);
  // R12: stalled bus request holds still
  a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)
                                       && $stable(bus_we_o) && $stable(bus_wdata_o)));
  // R6: load request held until accepted
  a_r6_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_o && !ld_ready_i) |=> ld_valid_o);
  // R9: copy request and its length held until accepted
  a_r9_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid_o && !cp_ready_i) |=> (cp_valid_o && $stable(cp_len_o)));
  // R8: success implies a well-formed length
  a_r8_done_len: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rsp_len_o >= 32'(MIN_RSP)));
endmodule

// File: tb/hcs_sequencer_bench.sv
`timescale 1ns/1ps
module hcs_sequencer_bench;
  localparam int CPU = 2;
  localparam logic [15:0] RSPA = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [15:0] cmd_size = 16'd64, max_rsp = 16'd256, cap_cmd = 16'd128, cap_rsp = 16'd256;
  logic busy, done, err, tmo, bus_valid, bus_ready, bus_we;
  logic [31:0] rsp_len, bus_wdata, bus_rdata, cp_len;
  logic [15:0] bus_addr;
  logic ld_valid, ld_ready, cp_valid, cp_ready;

  hcs_sequencer #(.CYC_PER_UNIT(CPU), .RSP_ADDR(RSPA)) u_hcs_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_size_i(cmd_size), .max_rsp_i(max_rsp),
    .cap_cmd_i(cap_cmd), .cap_rsp_i(cap_rsp), .busy_o(busy), .done_o(done), .err_o(err),
    .tmo_o(tmo), .rsp_len_o(rsp_len), .bus_valid_o(bus_valid), .bus_ready_i(bus_ready),
    .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .ld_valid_o(ld_valid), .ld_ready_i(ld_ready), .cp_valid_o(cp_valid), .cp_ready_i(cp_ready),
    .cp_len_o(cp_len));

  // ---------------- device model configuration (written by the test) ----------------
  logic [2:0] m_loc; bit m_need_req, m_never_asg, m_go_pre, m_go_never, m_sts_pre, m_sts_post, m_jitter;
  int m_go_polls, m_stall_go;
  logic [31:0] m_w0, m_w1;

  // ---------------- device model state (written by the model only) ----------------
  int cyc = 0, stall_left = 0, go_left = 0, go_wr_cyc = 0;
  bit req_seen = 0, started = 0;
  int n_bus = 0, n_lctrl = 0, n_req = 0, n_go = 0, n_ld = 0, n_cp = 0;
  logic [15:0] last_req_addr = '0, lctrl_addr = '0;
  logic [31:0] cp_len_seen = '0;

  assign bus_ready = (stall_left == 0) && !(m_jitter && (cyc % 3 == 0));
  assign ld_ready  = ld_valid && (cyc % 2 == 1);
  assign cp_ready  = cp_valid && (cyc % 2 == 0);

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == RSPA)            bus_rdata = m_w0;
    else if (bus_addr == RSPA + 16'd4) bus_rdata = m_w1;
    else case (bus_addr[11:0])
      12'h000: bus_rdata = {24'h0, 1'b1, 2'b00, m_loc, 
                            (!m_never_asg && (!m_need_req || req_seen)), 1'b0};
      12'h044: bus_rdata = {31'h0, (m_sts_pre || (m_sts_post && started))};
      12'h04C: bus_rdata = {31'h0, (m_go_pre || (started && (m_go_never || go_left != 0)))};
      default: bus_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stall_left > 0) stall_left <= stall_left - 1;
    if (!busy) begin req_seen <= 1'b0; started <= 1'b0; end
    if (bus_valid && bus_ready) begin
      n_bus <= n_bus + 1;
      if (bus_we) begin
        case (bus_addr[11:0])
          12'h008: begin n_lctrl <= n_lctrl + 1; lctrl_addr <= bus_addr; req_seen <= 1'b1; end
          12'h040: begin n_req <= n_req + 1; last_req_addr <= bus_addr; end
          12'h04C: begin n_go <= n_go + 1; started <= 1'b1; go_left <= m_go_polls;
                         go_wr_cyc <= cyc; stall_left <= m_stall_go; end
          default: ;
        endcase
      end else if (bus_addr[15] == 1'b0 && bus_addr[11:0] == 12'h04C && started && go_left > 0)
        go_left <= go_left - 1;
    end
    if (ld_valid && ld_ready) n_ld <= n_ld + 1;
    if (cp_valid && cp_ready) begin n_cp <= n_cp + 1; cp_len_seen <= cp_len; end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  typedef struct { int kind; logic [31:0] len; string req; } exp_t;
  exp_t sb[$];
  exp_t e_cur;
  int n_out = 0, out_cyc = 0, got_kind;

  // monitor: pops one expected outcome per observed pulse (0 done, 1 err, 2 tmo)
  always @(negedge clk) begin
    if (rst_n && (done || err || tmo)) begin
      n_out++;
      out_cyc = cyc;
      got_kind = done ? 0 : (err ? 1 : 2);
      if (sb.size() == 0) chk(1'b0, "R11 unexpected outcome", got_kind, -1);
      else begin
        e_cur = sb.pop_front();
        chk(got_kind == e_cur.kind, e_cur.req, got_kind, e_cur.kind);
        if (e_cur.kind == 0) chk(rsp_len == e_cur.len, e_cur.req, rsp_len, e_cur.len);
      end
    end
  end

  task automatic cfg_default();
    m_loc = 3'd0; m_need_req = 0; m_never_asg = 0; m_go_pre = 0; m_go_never = 0;
    m_sts_pre = 0; m_sts_post = 0; m_jitter = 1; m_go_polls = 4; m_stall_go = 0;
    m_w0 = 32'h0000_8001; m_w1 = 32'h0000_2301;   // length 0x123
    cmd_size = 16'd64; max_rsp = 16'd256; cap_cmd = 16'd128; cap_rsp = 16'd256;
  endtask

  task automatic wait_out(input int base);
    while (n_out == base) begin @(negedge clk); #0.5; end
  endtask

  task automatic run(input int kind, input logic [31:0] len, input string req);
    int base;
    sb.push_back('{kind, len, req});
    base = n_out;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; #0.5;
    wait_out(base);
    repeat (3) @(negedge clk);
    #0.5;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int b_bus, b_req, b_lc, b_go, b_ld, b_cp, b_out;
    cfg_default();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R10 reset state
    chk(!busy && !bus_valid, "R10 reset idle", {busy, bus_valid}, 0);
    chk({done, err, tmo} == 3'b000, "R10 reset outcomes", {done, err, tmo}, 0);

    // R1 command too large, then response buffer too small
    b_bus = n_bus; cmd_size = 16'd129;
    run(1, 0, "R1 cmd size");
    chk(n_bus == b_bus, "R1 no bus on cmd reject", n_bus - b_bus, 0);
    cmd_size = 16'd64; max_rsp = 16'd257; b_bus = n_bus;
    run(1, 0, "R1 rsp size");
    chk(n_bus == b_bus, "R1 no bus on rsp reject", n_bus - b_bus, 0);

    // normal, locality 0 assigned at once, jittered bus
    cfg_default();
    b_req = n_req; b_lc = n_lctrl; b_go = n_go; b_ld = n_ld; b_cp = n_cp;
    run(0, 32'h123, "R9 basic done");
    chk(n_req - b_req == 2, "R9 ready twice", n_req - b_req, 2);
    chk(n_lctrl == b_lc, "R3 no access request", n_lctrl - b_lc, 0);
    chk(n_go - b_go == 1 && n_ld - b_ld == 1, "R6 one load one start", n_go - b_go, 1);
    chk(n_cp - b_cp == 1 && cp_len_seen == 32'h123, "R9 copy length", cp_len_seen, 32'h123);
    chk(last_req_addr == 16'h0040, "R2 locality 0 address", last_req_addr, 16'h0040);

    // locality 3 needs an access request; length byte order
    cfg_default(); m_loc = 3'd3; m_need_req = 1; m_w0 = 32'h3412_0000; m_w1 = 32'h0000_7856;
    b_lc = n_lctrl;
    run(0, 32'h1234_5678, "R8 byte order");
    chk(n_lctrl - b_lc == 1 && lctrl_addr == 16'h3008, "R3 access request", lctrl_addr, 16'h3008);
    chk(last_req_addr == 16'h3040, "R2 locality 3 address", last_req_addr, 16'h3040);

    // locality 5 assigned at once passes the valid check without a request
    cfg_default(); m_loc = 3'd5; b_lc = n_lctrl;
    run(0, 32'h123, "R3 nonzero locality");
    chk(n_lctrl == b_lc && last_req_addr == 16'h5040, "R2 locality 5", last_req_addr, 16'h5040);

    // never assigned
    cfg_default(); m_never_asg = 1; b_lc = n_lctrl; b_req = n_req;
    run(2, 0, "R3 assign timeout");
    chk(n_lctrl - b_lc == 1 && n_req == b_req, "R3 one request no ready", n_lctrl - b_lc, 1);

    // start bit stuck before the command
    cfg_default(); m_go_pre = 1; b_req = n_req;
    run(2, 0, "R4 start busy");
    chk(n_req == b_req, "R4 no ready write", n_req - b_req, 0);

    // error bit stuck before execution
    cfg_default(); m_sts_pre = 1; b_go = n_go;
    run(1, 0, "R5 status error");
    chk(n_go == b_go, "R5 no start", n_go - b_go, 0);

    // execution never completes; timeout timing
    cfg_default(); m_go_never = 1; m_jitter = 0; b_cp = n_cp;
    run(2, 0, "R6 exec timeout");
    chk(out_cyc - go_wr_cyc >= 3500 * CPU && out_cyc - go_wr_cyc <= 3500 * CPU + 10,
        "R13 exec budget", out_cyc - go_wr_cyc, 3500 * CPU + 2);
    chk(n_cp == b_cp, "R6 no copy", n_cp - b_cp, 0);

    // error after completion
    cfg_default(); m_sts_post = 1; b_cp = n_cp;
    run(1, 0, "R7 end error");
    chk(n_cp == b_cp, "R7 no copy", n_cp - b_cp, 0);

    // short response and the boundary length
    cfg_default(); m_w1 = 32'h0000_0500; b_cp = n_cp;
    run(1, 0, "R8 short length");
    chk(n_cp == b_cp, "R8 no copy", n_cp - b_cp, 0);
    cfg_default(); m_w1 = 32'h0000_0600;
    run(0, 32'd6, "R8 minimum length");

    // stall past the budget then a matching read: success
    cfg_default(); m_jitter = 0; m_go_polls = 0; m_stall_go = 3500 * CPU + 20;
    run(0, 32'h123, "R13 late match");

    // start while busy is ignored
    cfg_default(); m_go_polls = 60; b_req = n_req; b_out = n_out;
    sb.push_back('{0, 32'h123, "R11 busy start"});
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0; #0.5;
    wait_out(b_out);
    repeat (40) @(negedge clk); #0.5;
    chk(n_out - b_out == 1 && n_req - b_req == 2, "R11 single transaction", n_out - b_out, 1);

    // start in the same cycle as done starts a second transaction
    cfg_default(); b_out = n_out;
    sb.push_back('{0, 32'h123, "R11 back to back first"});
    sb.push_back('{0, 32'h123, "R11 back to back second"});
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; #0.5;
    wait_out(b_out);
    start = 1'b1;
    @(negedge clk); start = 1'b0; #0.5;
    wait_out(b_out + 1);
    repeat (10) @(negedge clk); #0.5;
    chk(n_out - b_out == 2, "R11 restart on done cycle", n_out - b_out, 2);
    chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);

    summary();
    $finish;
  end
endmodule